// File: doc/BRIEF.md
# Clock Generator Mode Selector

This block decides which operating mode a clock generator runs in. Software supplies a 2-bit requested mode code. Three stability and loss flags report on the oscillator and the external reference, and an off request can shut the generator down. Each requested mode is guarded by the flags it depends on. When a guard is not met, the block stays in, or returns to, the self-clocked mode, where the DCO runs open loop.

If the DCO clock is lost while the FLL is locked to the external reference, the block falls back to passing the external reference straight through. The block also remembers the requested code and the external-reference state that were present when the off state was entered. When off is released, it uses those saved values to pick the mode it resumes in.

The block has five mode codes: 000 self-clocked, 001 FLL on internal reference, 010 external reference bypass, 011 FLL on external reference, and 100 off. The outputs are the mode code, a DCO enable, an internal-reference enable and the clock-source select. All flags arrive already synchronized. Every mode change takes effect on the clock edge after the inputs that cause it.

Top module: `clkmode_fsm`

## Requirements
- R1: After reset the mode is 000 (self-clocked), the DCO enable is 1, the internal-reference enable is 0, the source select is 0, and the saved select code is 00.
- R2: `off_req` high overrides every other input. On the next edge the mode becomes 100. On entry from a mode other than 100, `sel_req` and `ext_ok` are saved.
- R3: With select 00, and neither off nor its exit applying, the next mode is 000.
- R4: With select 01, the next mode is 001 when `dco_ok` is high and `dco_lost` is low, and 000 otherwise. This includes moving up from 000 once the DCO becomes stable after off is released.
- R5: With select 10, the next mode is 010 when `ext_ok` is high, and 000 otherwise.
- R6: With select 11, the next mode is 011 when `ext_ok` and `dco_ok` are both high and `dco_lost` is low.
- R7: With select 11, if `dco_lost` is high and `ext_ok` is high while the mode is 011 or 010, the next mode is 010. With select 11 and the guards of R6 not met otherwise, the next mode is 000.
- R8: When off is released (mode 100 with `off_req` low), the next mode is 010 if the saved select was 10 and the saved external flag was 1. Otherwise it is 000, whatever the current inputs are.
- R9: The outputs follow the mode. `dco_en` is 1 in modes 000, 001 and 011. `irc_en` is 1 only in 001. `src_ext` (1 = external reference drives the output clock, 0 = DCO) is 1 only in 010. All three are 0 in 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_req | input | 2 | Requested mode code |
| dco_ok | input | 1 | DCO clock stable |
| ext_ok | input | 1 | External reference stable |
| dco_lost | input | 1 | DCO clock lost |
| off_req | input | 1 | Request to enter off |
| mode | output | 3 | Current mode code |
| dco_en | output | 1 | DCO enable |
| irc_en | output | 1 | Internal reference enable |
| src_ext | output | 1 | Output clock source: 1 external, 0 DCO |

## Verification
The mode register drives every output, so a wrong next-state decision appears on `mode` and on the enables one edge after the inputs that caused it. A wrong saved select or saved external flag stays hidden until off is released, and then shows as the wrong resume mode on the first edge afterwards. The bench therefore checks every cycle of random traffic against a reference model, and adds directed off-and-resume sequences whose saved values differ from the inputs present on release.

// File: rtl/clkmode_fsm.sv
module clkmode_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_req,
  input  logic       dco_ok,
  input  logic       ext_ok,
  input  logic       dco_lost,
  input  logic       off_req,
  output logic [2:0] mode,
  output logic       dco_en,
  output logic       irc_en,
  output logic       src_ext
);

  typedef enum logic [2:0] {
    M_SCM = 3'b000,
    M_FEI = 3'b001,
    M_FBE = 3'b010,
    M_FEE = 3'b011,
    M_OFF = 3'b100
  } mode_t;

  mode_t      st, nx;
  logic [1:0] keep_sel;
  logic       keep_ext;
  logic       dco_good;

  assign dco_good = dco_ok & ~dco_lost;

  always_comb begin
    nx = M_SCM;
    if (off_req)
      nx = M_OFF;
    else if (st == M_OFF)
      nx = (keep_sel == 2'b10 && keep_ext) ? M_FBE : M_SCM;
    else
      case (sel_req)
        2'b01: nx = dco_good ? M_FEI : M_SCM;
        2'b10: nx = ext_ok ? M_FBE : M_SCM;
        2'b11: begin
          if (ext_ok && dco_good)
            nx = M_FEE;
          else if (ext_ok && dco_lost && (st == M_FEE || st == M_FBE))
            nx = M_FBE;
          else
            nx = M_SCM;
        end
        default: nx = M_SCM;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_SCM;
      keep_sel <= 2'b00;
      keep_ext <= 1'b0;
    end else begin
      st <= nx;
      if (off_req && st != M_OFF) begin
        keep_sel <= sel_req;
        keep_ext <= ext_ok;
      end
    end
  end

  assign mode    = st;
  assign dco_en  = (st == M_SCM) || (st == M_FEI) || (st == M_FEE);
  assign irc_en  = (st == M_FEI);
  assign src_ext = (st == M_FBE);

  assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> mode == 3'b100);

  assert_sel0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && mode != 3'b100 && sel_req == 2'b00) |=> mode == 3'b000);

  assert_fei_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && mode != 3'b100 && sel_req == 2'b01 && (!dco_ok || dco_lost))
      |=> mode == 3'b000);

  assert_fbe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && mode != 3'b100 && sel_req == 2'b10 && ext_ok) |=> mode == 3'b010);

  assert_fee_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && mode != 3'b100 && sel_req == 2'b11 && ext_ok && dco_ok && !dco_lost)
      |=> mode == 3'b011);

  assert_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && mode == 3'b011 && sel_req == 2'b11 && dco_lost && ext_ok)
      |=> mode == 3'b010);

  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && mode == 3'b100) |=> (mode == 3'b010 || mode == 3'b000));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> (!dco_en && !irc_en && !src_ext));

endmodule

// File: tb/test_clkmode_fsm.sv
`timescale 1ns/1ps
module test_clkmode_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel_req = 2'b00;
  logic dco_ok = 1'b0, ext_ok = 1'b0, dco_lost = 1'b0, off_req = 1'b0;
  logic [2:0] mode;
  logic dco_en, irc_en, src_ext;

  int checks = 0;
  int fails = 0;
  logic [2:0] exp_mode;
  logic [1:0] m_sel;
  logic m_ext;
  string tag;

  always #2.5 clk = ~clk;

  clkmode_fsm i_clkmode_fsm (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .dco_ok(dco_ok), .ext_ok(ext_ok),
    .dco_lost(dco_lost), .off_req(off_req), .mode(mode), .dco_en(dco_en),
    .irc_en(irc_en), .src_ext(src_ext)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] cur, input logic [1:0] s,
      input logic d, input logic e, input logic l, input logic o,
      input logic [1:0] ks, input logic ke);
    if (o) return 3'b100;
    if (cur == 3'b100) return (ks == 2'b10 && ke) ? 3'b010 : 3'b000;
    case (s)
      2'b01: return (d && !l) ? 3'b001 : 3'b000;
      2'b10: return e ? 3'b010 : 3'b000;
      2'b11: begin
        if (e && d && !l) return 3'b011;
        if (e && l && (cur == 3'b011 || cur == 3'b010)) return 3'b010;
        return 3'b000;
      end
      default: return 3'b000;
    endcase
  endfunction

  function automatic string ref_tag(input logic [2:0] cur, input logic [1:0] s,
      input logic l, input logic o);
    if (o) return "R2";
    if (cur == 3'b100) return "R8";
    case (s)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return l ? "R7" : "R6";
    endcase
  endfunction

  task automatic check_outputs(input string t);
    logic [2:0] eo;
    eo = {(exp_mode == 3'b000 || exp_mode == 3'b001 || exp_mode == 3'b011),
          (exp_mode == 3'b001), (exp_mode == 3'b010)};
    checks++;
    if (mode !== exp_mode) begin
      fails++;
      $display("FAIL %s mode actual=%b expected=%b", t, mode, exp_mode);
    end
    checks++;
    if ({dco_en, irc_en, src_ext} !== eo) begin
      fails++;
      $display("FAIL R9 enables actual=%b expected=%b", {dco_en, irc_en, src_ext}, eo);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic d, input logic e,
                      input logic l, input logic o);
    sel_req = s; dco_ok = d; ext_ok = e; dco_lost = l; off_req = o;
    tag = ref_tag(exp_mode, s, l, o);
    if (o && exp_mode != 3'b100) begin
      m_sel = s; m_ext = e;
    end
    exp_mode = ref_next(exp_mode, s, d, e, l, o, m_sel, m_ext);
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    exp_mode = 3'b000; m_sel = 2'b00; m_ext = 1'b0;
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1");

    // R4: self-clocked until DCO stable, then internal engaged
    step(2'b01, 0, 0, 0, 0);
    step(2'b01, 1, 0, 0, 0);
    // R5 / R6 / R7: engaged external, DCO loss falls back to bypass
    step(2'b10, 1, 1, 0, 0);
    step(2'b11, 1, 1, 0, 0);
    step(2'b11, 0, 1, 1, 0);
    step(2'b11, 0, 1, 1, 0);
    step(2'b11, 0, 0, 1, 0);
    // R8: off entered with select 10 and ext stable resumes in bypass
    step(2'b10, 1, 1, 0, 0);
    step(2'b10, 1, 1, 0, 1);
    step(2'b01, 1, 0, 0, 1);
    step(2'b01, 0, 0, 0, 0);
    // R8: off entered with select 01 resumes self-clocked, then R4 moves up
    step(2'b01, 1, 1, 0, 1);
    step(2'b10, 1, 1, 0, 0);
    step(2'b01, 1, 1, 0, 0);
    // R8: select 10 with ext unstable at off entry
    step(2'b10, 1, 0, 0, 1);
    step(2'b10, 1, 1, 0, 0);
    // R3
    step(2'b00, 1, 1, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      step(2'($urandom_range(3)), ($urandom_range(3) != 0), ($urandom_range(3) != 0),
           ($urandom_range(7) == 0), ($urandom_range(15) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule